// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral core and hands that state to the data path. Software writes a two-bit code into a state register to ask for RESET, RUN or PAUSE. It reads the same register back to learn the current state and whether the core has settled. After every accepted request the block lowers a settled flag for a fixed number of cycles. This models the time the core needs to finish a transition. Software waits for the flag before it makes the next request.

A transfer normally goes through RESET, RUN, PAUSE, RUN and RESET, in that order. In the PAUSE step, software preloads the output FIFO. Leaving PAUSE for RESET is deliberately awkward: it takes two consecutive accepted writes of the clear code. A separate soft-reset register forces RESET at any time. Each entry into RESET sends a one-cycle clear pulse to the FIFOs and transfer counters. The run and pause enables are driven only while the core is settled in the matching state.

Top module: `periph_state_ctl`

## Requirements
- R1: After a synchronous active-low reset, the state is RESET, the settled flag is 1, the busy-write flag is 0, and `run_en`, `pause_en` and `fifo_clr` are 0.
- R2: `rd_data` carries the state code in bits [1:0] (RESET=0, RUN=1, PAUSE=3), the settled flag in bit 2 and the busy-write flag in bit 3. All other bits read 0. The code 2 is never reported as a state.
- R3: An accepted write to the state register (`wr_sel`=0) with code 0, 1 or 3 moves the state to that code from RESET or RUN. From PAUSE, codes 1 and 3 move the state directly.
- R4: Every accepted state write, and every soft reset, holds the settled flag low for exactly SETTLE cycles (default 4). The flag then returns to 1.
- R5: A state write that arrives while the settled flag is low is ignored: state and settling are unchanged. It sets the busy-write flag, which stays set until a reset or soft reset.
- R6: From PAUSE, the first accepted write of code 2 leaves the state in PAUSE. A second accepted write of code 2 that directly follows it moves the state to RESET. Any other accepted write in between cancels the pending first write.
- R7: Code 2 written from RESET or RUN, and code 0 written from PAUSE, leave the state unchanged. These writes still start a settling period.
- R8: A write to the soft-reset register (`wr_sel`=1) with bit 0 set forces RESET from any state, even while settling. It clears the busy-write flag and starts a settling period. With bit 0 clear, such a write has no effect.
- R9: `fifo_clr` is high for exactly the one cycle after each write that puts the state into RESET, including a soft reset. It is never high otherwise.
- R10: `run_en` is high only when the state is RUN and the settled flag is 1. `pause_en` is high only when the state is PAUSE and the settled flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 state register, 1 soft-reset register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | State register read-back |
| run_en | output | 1 | Data path run enable |
| pause_en | output | 1 | Data path pause enable |
| fifo_clr | output | 1 | One-cycle clear for FIFOs and transfer counters |

## Verification
The request patterns cover:
- the full transfer sequence through every state, which confirms the direct transitions and the enable outputs;
- a single clear write from PAUSE, a double clear write, and a double clear write broken by another write, which separates a correct two-write exit from an exit on one write or an arming flag that never clears;
- codes that are illegal from the current state, which shows whether they are ignored or taken;
- writes issued during settling and soft resets, which show whether a request is lost, obeyed, or wrongly flagged, and whether the clear pulse follows only real entries into RESET.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
// Shared types for the run-state controller: the two-bit operating codes
// and the read-back bit positions that software decodes.
package psc_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_RUN   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_PAUSE = 2'd3
    } op_code_t;

    localparam int CODE_W      = 2;
    localparam int VALID_BIT   = 2;
    localparam int ILLEGAL_BIT = 3;
endpackage

// File: rtl/psc_settle_timer.sv
`timescale 1ns/1ps
// Settling timer: a load starts a down-count of SETTLE cycles; settled is
// high whenever the count is zero. Assumes SETTLE >= 1.
module psc_settle_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic settled
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on a transition, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(SETTLE);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign settled = (cnt_q == '0);

    AST_SETTLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !settled); // R4
    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SETTLE)); // R4
endmodule

// File: rtl/psc_state_core.sv
`timescale 1ns/1ps
// State core: decides the next operating state from an accepted request,
// including the two-write exit from PAUSE, and registers the clear pulse.
// Assumes req_valid is only raised for requests the caller has accepted.
module psc_state_core
    import psc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  op_code_t req_code,
    input  logic     force_reset,
    output op_code_t state,
    output logic     clr_pulse
);
    op_code_t state_q, state_d;
    logic     arm_q, arm_d;
    logic     enter_reset;

    // Next-state decode; arm records a first clear write made in PAUSE.
    always_comb begin
        state_d     = state_q;
        arm_d       = arm_q;
        enter_reset = 1'b0;
        if (force_reset) begin
            state_d     = OP_RESET;
            arm_d       = 1'b0;
            enter_reset = 1'b1;
        end else if (req_valid) begin
            arm_d = 1'b0;
            if (state_q == OP_PAUSE) begin
                case (req_code)
                    OP_RUN, OP_PAUSE: state_d = req_code;
                    OP_CLEAR: begin
                        if (arm_q) begin
                            state_d     = OP_RESET;
                            enter_reset = 1'b1;
                        end else begin
                            arm_d = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (req_code != OP_CLEAR) begin
                state_d     = req_code;
                enter_reset = (req_code == OP_RESET);
            end
        end
    end

    // State, arm and clear-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= OP_RESET;
            arm_q     <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            state_q   <= state_d;
            arm_q     <= arm_d;
            clr_pulse <= enter_reset;
        end
    end

    assign state = state_q;

    AST_NO_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != OP_CLEAR); // R2
    AST_PAUSE_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OP_PAUSE && !arm_q && !force_reset) |=> state_q != OP_RESET); // R6
    AST_ARM_ONLY_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> state_q == OP_PAUSE); // R6
endmodule

// File: rtl/periph_state_ctl.sv
`timescale 1ns/1ps
// Peripheral run-state controller top: register write decode, busy-write
// flag, read-back assembly and data path enables. Assumes one register
// write per cycle and DATA_W >= 4.
module periph_state_ctl
    import psc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              run_en,
    output logic              pause_en,
    output logic              fifo_clr
);
    logic     settled;
    logic     accept, busy_wr, soft_rst, load;
    logic     illegal_q;
    op_code_t state;
    logic     unused_hi;

    assign accept    = wr_en && !wr_sel && settled;
    assign busy_wr   = wr_en && !wr_sel && !settled;
    assign soft_rst  = wr_en && wr_sel && wr_data[0];
    assign load      = accept || soft_rst;
    assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

    psc_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .settled (settled)
    );

    psc_state_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (accept),
        .req_code    (op_code_t'(wr_data[CODE_W-1:0])),
        .force_reset (soft_rst),
        .state       (state),
        .clr_pulse   (fifo_clr)
    );

    // Sticky flag for state writes made before the core settled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_q <= 1'b0;
        else if (soft_rst)
            illegal_q <= 1'b0;
        else if (busy_wr)
            illegal_q <= 1'b1;
    end

    // Read-back word: state code, settled flag, busy-write flag.
    always_comb begin
        rd_data                 = '0;
        rd_data[CODE_W-1:0]     = state;
        rd_data[VALID_BIT]      = settled;
        rd_data[ILLEGAL_BIT]    = illegal_q;
    end

    assign run_en   = settled && (state == OP_RUN);
    assign pause_en = settled && (state == OP_PAUSE);

    AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_en, pause_en})); // R10
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wr |=> $stable(state)); // R5
    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_q && !soft_rst) |=> illegal_q); // R5
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == OP_RESET) && !settled && !illegal_q); // R8
    AST_CLR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> state == OP_RESET); // R9
endmodule

// File: tb/test_periph_state_ctl.sv
`timescale 1ns/1ps
module test_periph_state_ctl;
    localparam int DW = 8;
    localparam int ST = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          run_en, pause_en, fifo_clr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    periph_state_ctl #(.DATA_W(DW), .SETTLE(ST)) i_periph_state_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_data(rd_data), .run_en(run_en),
        .pause_en(pause_en), .fifo_clr(fifo_clr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One-cycle register write; returns at the negedge after the write edge.
    task automatic wr(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    task automatic settle();
        repeat (ST) @(negedge clk);
    endtask

    task automatic go(input logic [1:0] code);
        wr(1'b0, {6'd0, code});
        settle();
    endtask

    task automatic t_reset();
        chk("R1", "rd_data", rd_data, 8'h04);
        chk("R1", "run_en", run_en, 0);
        chk("R1", "pause_en", pause_en, 0);
        chk("R1", "fifo_clr", fifo_clr, 0);
    endtask

    task automatic t_sequence();
        wr(1'b0, 8'd1);
        for (int i = 0; i < ST; i++) begin
            chk("R4", "settled low", rd_data[2], 0);
            chk("R10", "run_en during settle", run_en, 0);
            @(negedge clk);
        end
        chk("R4", "settled back", rd_data[2], 1);
        chk("R3", "RUN read-back", rd_data, 8'h05);
        chk("R10", "run_en", run_en, 1);
        go(2'd3);
        chk("R3", "PAUSE read-back", rd_data, 8'h07);
        chk("R10", "pause_en", pause_en, 1);
        chk("R10", "run_en in pause", run_en, 0);
        go(2'd1);
        chk("R3", "RUN from PAUSE", rd_data, 8'h05);
        wr(1'b0, 8'd0);
        chk("R9", "clr after RESET write", fifo_clr, 1);
        @(negedge clk);
        chk("R9", "clr one cycle", fifo_clr, 0);
        repeat (ST - 1) @(negedge clk);
        chk("R3", "RESET from RUN", rd_data, 8'h04);
    endtask

    task automatic t_pause_clear();
        go(2'd1); go(2'd3);
        wr(1'b0, 8'd2);
        chk("R9", "no clr on first clear", fifo_clr, 0);
        settle();
        chk("R6", "still PAUSE after one clear", rd_data, 8'h07);
        wr(1'b0, 8'd2);
        chk("R9", "clr on second clear", fifo_clr, 1);
        settle();
        chk("R6", "RESET after two clears", rd_data, 8'h04);
    endtask

    task automatic t_cancel();
        go(2'd1); go(2'd3);
        go(2'd2); go(2'd3); go(2'd2);
        chk("R6", "cancelled clear pair", rd_data, 8'h07);
        go(2'd2);
        chk("R6", "RESET after new pair", rd_data, 8'h04);
    endtask

    task automatic t_unknown();
        wr(1'b0, 8'd2);
        chk("R7", "settle on ignored code", rd_data[2], 0);
        chk("R9", "no clr from code 2 in RESET", fifo_clr, 0);
        settle();
        chk("R7", "RESET kept on code 2", rd_data, 8'h04);
        go(2'd1); go(2'd2);
        chk("R7", "RUN kept on code 2", rd_data, 8'h05);
        go(2'd3); go(2'd0);
        chk("R7", "PAUSE kept on code 0", rd_data, 8'h07);
        go(2'd1);
    endtask

    task automatic t_busy();
        wr(1'b0, 8'd3);
        wr(1'b0, 8'd0);
        settle();
        chk("R5", "busy write ignored", rd_data[1:0], 2'd3);
        chk("R5", "busy flag set", rd_data[3], 1);
        chk("R5", "pause_en after busy", pause_en, 1);
        go(2'd1);
        chk("R5", "busy flag sticky", rd_data, 8'h0D);
    endtask

    task automatic t_swrst();
        wr(1'b1, 8'hFE);
        chk("R8", "bit0 clear no effect", rd_data, 8'h0D);
        chk("R8", "no clr on bit0 clear", fifo_clr, 0);
        wr(1'b1, 8'h01);
        chk("R8", "soft reset read-back", rd_data, 8'h00);
        chk("R9", "clr on soft reset", fifo_clr, 1);
        settle();
        chk("R8", "settled after soft reset", rd_data, 8'h04);
        wr(1'b0, 8'd1);
        wr(1'b1, 8'h01);
        chk("R9", "clr on soft reset in settle", fifo_clr, 1);
        settle();
        chk("R8", "soft reset during settle", rd_data, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_pause_clear();
        t_cancel();
        t_unknown();
        t_busy();
        t_swrst();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule